// File: doc/BRIEF.md
# Next-PC Sequencing Unit

This block holds the program counter of a processor with fixed 32-bit, word-aligned instructions and chooses, on every clock edge, the address the counter moves to next. Three candidates are formed in parallel: the following instruction word (current PC plus four), a PC-relative branch target taken from the signed 16-bit immediate of the current instruction, and a region-relative jump target taken from its 26-bit index field. The counter has no write enable: it loads a new value on every clock edge.

The decode and compare logic around it supplies three qualifiers: a branch enable from the decoder, the zero result of the comparison, and a jump select. A branch is taken only when both the enable and the zero flag are high. A jump wins over everything else. The branch target and the jump region are both based on PC plus four, not on the current PC. Because of this, an offset of minus one branches back onto the same instruction, and a jump from the last word of a 256 MiB region lands in the next region.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC loads 0x00000000 after that edge, whatever the other inputs are.
- R2: With `jmp_sel` low and no branch taken, every clock edge advances the PC by exactly 4.
- R3: With `br_en` and `cmp_zero` both high and `jmp_sel` low, the next PC equals PC + 4 + (instruction bits [15:0] sign-extended and multiplied by 4).
- R4: If only one of `br_en` and `cmp_zero` is high, the branch immediate has no effect and the PC advances by 4.
- R5: Bit 15 of the branch immediate is its sign. A negative immediate moves the PC backwards. The value 0xFFFF gives a next PC equal to the current PC, so the unit stays on one instruction for as long as that branch is taken.
- R6: With `jmp_sel` high, the next PC is formed from bits [31:28] of PC + 4, then instruction bits [25:0], then two zero bits. Instruction bits [31:26] have no effect on it.
- R7: `jmp_sel` has priority: when it is high, the jump target is loaded even if a branch would be taken.
- R8: PC bits [1:0] read as zero at all times.
- R9: The upper four bits of a jump target come from PC + 4. A jump whose PC + 4 has already crossed into the next 256 MiB region lands in that new region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC loads on every rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Instruction currently fetched at the PC |
| br_en | input | 1 | Decoder flag marking the instruction as a conditional branch |
| cmp_zero | input | 1 | Zero result of the operand comparison |
| jmp_sel | input | 1 | Selects the jump target; highest priority |
| pc_q | output | 32 | Current program counter |

## Verification
Each result of this block appears one clock edge after its stimulus. The next-address logic is purely combinational, and the only register on the path is the PC itself. The bench therefore drives the instruction and the three qualifiers one time unit after a rising edge. It waits for the next rising edge, samples `pc_q` one time unit later, and compares it with an expected PC. That expected PC is kept in the bench and advanced by the rules above. Cases that repeat an address, such as the minus-one branch loop, are sampled on several consecutive edges, so that an unchanged PC is confirmed edge by edge.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   // Which candidate feeds the PC register on the coming edge.
   typedef enum logic [1:0] {
      NXT_SEQ    = 2'd0,
      NXT_BRANCH = 2'd1,
      NXT_JUMP   = 2'd2
   } nxt_sel_e;

   localparam int unsigned WORD_SHIFT = 2;   // byte address = word index << 2
   localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/pcseq_adder.sv
module pcseq_adder #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] sum
);
   // Modulo-2^W adder; carry out is not used by the sequencer.
   assign sum = op_a + op_b;
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OFFS_W  = 16,
   parameter int unsigned JIDX_W  = 26
) (
   input  logic [ADDR_W-1:0]  pc_cur,
   input  logic [INSTR_W-1:0] instr_word,
   output logic [ADDR_W-1:0]  pc_inc,
   output logic [ADDR_W-1:0]  br_tgt,
   output logic [ADDR_W-1:0]  jmp_tgt
);
   localparam int unsigned EXT_W    = ADDR_W - OFFS_W - WORD_SHIFT;
   localparam int unsigned REGION_W = ADDR_W - JIDX_W - WORD_SHIFT;

   logic [ADDR_W-1:0] branch_disp;
   logic [OFFS_W-1:0] imm_field;
   logic [JIDX_W-1:0] idx_field;

   assign imm_field = instr_word[OFFS_W-1:0];
   assign idx_field = instr_word[JIDX_W-1:0];

   // Sequential adder: PC + one instruction word.
   pcseq_adder #(.W(ADDR_W)) u_inc_add (
      .op_a (pc_cur),
      .op_b (ADDR_W'(WORD_BYTES)),
      .sum  (pc_inc)
   );

   // Sign extension followed by the word shift.
   generate
      if (EXT_W > 0) begin : g_sext
         assign branch_disp = {{EXT_W{imm_field[OFFS_W-1]}}, imm_field, {WORD_SHIFT{1'b0}}};
      end else begin : g_noext
         assign branch_disp = {imm_field, {WORD_SHIFT{1'b0}}};
      end
   endgenerate

   // Branch adder: PC + 4 + displacement.
   pcseq_adder #(.W(ADDR_W)) u_br_add (
      .op_a (pc_inc),
      .op_b (branch_disp),
      .sum  (br_tgt)
   );

   // Region splice: the upper bits of PC + 4, then the shifted index.
   generate
      if (REGION_W > 0) begin : g_region
         assign jmp_tgt = {pc_inc[ADDR_W-1 -: REGION_W], idx_field, {WORD_SHIFT{1'b0}}};
      end else begin : g_flat
         assign jmp_tgt = {idx_field, {WORD_SHIFT{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              br_en,
   input  logic              cmp_zero,
   input  logic              jmp_sel,
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [ADDR_W-1:0] br_tgt,
   input  logic [ADDR_W-1:0] jmp_tgt,
   output nxt_sel_e          sel,
   output logic [ADDR_W-1:0] pc_next
);
   logic take_branch;

   assign take_branch = br_en & cmp_zero;

   // Jump first, then the branch condition, then fall through.
   always_comb begin
      if (jmp_sel)          sel = NXT_JUMP;
      else if (take_branch) sel = NXT_BRANCH;
      else                  sel = NXT_SEQ;
   end

   always_comb begin
      unique case (sel)
         NXT_JUMP:   pc_next = jmp_tgt;
         NXT_BRANCH: pc_next = br_tgt;
         default:    pc_next = pc_inc;
      endcase
   end
endmodule

// File: rtl/pcseq_reg.sv
module pcseq_reg
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter bit          TRIM_LOW = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] pc_next,
   output logic [ADDR_W-1:0] pc_q
);
   localparam int unsigned IDX_W = ADDR_W - WORD_SHIFT;

   generate
      if (TRIM_LOW) begin : g_word_idx
         // Store only the word index; the byte offset is tied to zero.
         logic [IDX_W-1:0] idx_q;
         logic [WORD_SHIFT-1:0] unused_byte_bits;
         assign unused_byte_bits = pc_next[WORD_SHIFT-1:0];
         always_ff @(posedge clk) begin
            if (rst) idx_q <= RESET_PC[ADDR_W-1:WORD_SHIFT];
            else     idx_q <= pc_next[ADDR_W-1:WORD_SHIFT];
         end
         assign pc_q = {idx_q, {WORD_SHIFT{1'b0}}};
      end else begin : g_full
         logic [ADDR_W-1:0] full_q;
         always_ff @(posedge clk) begin
            if (rst) full_q <= RESET_PC;
            else     full_q <= pc_next;
         end
         assign pc_q = full_q;
      end
   endgenerate
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned INSTR_W  = 32,
   parameter int unsigned OFFS_W   = 16,
   parameter int unsigned JIDX_W   = 26,
   parameter bit          TRIM_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic               br_en,
   input  logic               cmp_zero,
   input  logic               jmp_sel,
   output logic [ADDR_W-1:0]  pc_q
);
   localparam logic [ADDR_W-1:0] RESET_PC = '0;

   // Elaboration-time parameter checks.
   generate
      if (JIDX_W + WORD_SHIFT > ADDR_W) begin : g_bad_jidx
         $error("pc_sequencer: JIDX_W + 2 must not exceed ADDR_W");
      end
      if (OFFS_W + WORD_SHIFT > ADDR_W) begin : g_bad_offs
         $error("pc_sequencer: OFFS_W + 2 must not exceed ADDR_W");
      end
      if (JIDX_W > INSTR_W || OFFS_W > INSTR_W) begin : g_bad_instr
         $error("pc_sequencer: instruction fields wider than INSTR_W");
      end
      if (INSTR_W > JIDX_W) begin : g_opc_sink
         logic [INSTR_W-JIDX_W-1:0] unused_opc_bits;
         assign unused_opc_bits = instr_word[INSTR_W-1:JIDX_W];
      end
   endgenerate

   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] br_tgt;
   logic [ADDR_W-1:0] jmp_tgt;
   logic [ADDR_W-1:0] pc_next;
   nxt_sel_e          nxt_sel;

   pcseq_target #(
      .ADDR_W  (ADDR_W),
      .INSTR_W (INSTR_W),
      .OFFS_W  (OFFS_W),
      .JIDX_W  (JIDX_W)
   ) u_target (
      .pc_cur     (pc_q),
      .instr_word (instr_word),
      .pc_inc     (pc_inc),
      .br_tgt     (br_tgt),
      .jmp_tgt    (jmp_tgt)
   );

   pcseq_select #(.ADDR_W(ADDR_W)) u_select (
      .br_en    (br_en),
      .cmp_zero (cmp_zero),
      .jmp_sel  (jmp_sel),
      .pc_inc   (pc_inc),
      .br_tgt   (br_tgt),
      .jmp_tgt  (jmp_tgt),
      .sel      (nxt_sel),
      .pc_next  (pc_next)
   );

   pcseq_reg #(
      .ADDR_W   (ADDR_W),
      .TRIM_LOW (TRIM_LOW),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk     (clk),
      .rst     (rst),
      .pc_next (pc_next),
      .pc_q    (pc_q)
   );
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OFFS_W  = 16,
   parameter int unsigned JIDX_W  = 26
) (
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr_word,
   input logic               br_en,
   input logic               cmp_zero,
   input logic               jmp_sel,
   input logic [ADDR_W-1:0]  pc_q
);
   localparam int unsigned EXT_W    = ADDR_W - OFFS_W - 2;
   localparam int unsigned REGION_W = ADDR_W - JIDX_W - 2;

   logic [ADDR_W-1:0] seq_ref;
   logic [ADDR_W-1:0] disp_ref;
   logic [ADDR_W-1:0] jump_ref;

   assign seq_ref  = pc_q + ADDR_W'(4);
   assign disp_ref = ADDR_W'($signed(instr_word[OFFS_W-1:0])) << 2;
   assign jump_ref = {seq_ref[ADDR_W-1 -: REGION_W], instr_word[JIDX_W-1:0], 2'b00};

   // R1: reset loads address zero
   p_reset_zero_r1: assert property (@(posedge clk) rst |=> pc_q == '0);

   // R2 and R4: no jump and no taken branch means a plain word step
   p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
      (!jmp_sel && !(br_en && cmp_zero)) |=> pc_q == $past(seq_ref));

   // R3 and R5: taken branch lands at PC + 4 + scaled signed offset
   p_branch_tgt_r3: assert property (@(posedge clk) disable iff (rst)
      (!jmp_sel && br_en && cmp_zero) |=> pc_q == $past(seq_ref + disp_ref));

   // R6, R7 and R9: jump wins and keeps the region of PC + 4
   p_jump_tgt_r6: assert property (@(posedge clk) disable iff (rst)
      jmp_sel |=> pc_q == $past(jump_ref));

   // R8: byte offset bits stay clear
   p_word_align_r8: assert property (@(posedge clk) disable iff (rst)
      pc_q[1:0] == 2'b00);

   logic [EXT_W-1:0] unused_ext;
   assign unused_ext = '0;
endmodule

bind pc_sequencer pc_sequencer_chk #(
   .ADDR_W  (ADDR_W),
   .INSTR_W (INSTR_W),
   .OFFS_W  (OFFS_W),
   .JIDX_W  (JIDX_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .instr_word (instr_word),
   .br_en      (br_en),
   .cmp_zero   (cmp_zero),
   .jmp_sel    (jmp_sel),
   .pc_q       (pc_q)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_word = '0;
   logic        br_en = 1'b0;
   logic        cmp_zero = 1'b0;
   logic        jmp_sel = 1'b0;
   logic [31:0] pc_q;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] exp_pc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_sequencer u_dut (
      .clk        (clk),
      .rst        (rst),
      .instr_word (instr_word),
      .br_en      (br_en),
      .cmp_zero   (cmp_zero),
      .jmp_sel    (jmp_sel),
      .pc_q       (pc_q)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: pc actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one cycle of inputs, let one edge pass, sample just after it.
   task automatic step(input logic [31:0] iw, input logic be, input logic cz,
                       input logic js, input logic [31:0] expect_pc, input string req);
      instr_word = iw; br_en = be; cmp_zero = cz; jmp_sel = js;
      @(posedge clk); #1;
      exp_pc = expect_pc;
      check(req, pc_q, exp_pc);
      check("R8", {30'd0, pc_q[1:0]}, 32'd0);
   endtask

   task automatic t_reset();
      rst = 1'b1; jmp_sel = 1'b1; instr_word = 32'h03FF_FFFF;
      @(posedge clk); @(posedge clk); #1;
      exp_pc = 32'd0;
      check("R1 reset value", pc_q, 32'd0);
      rst = 1'b0;
   endtask

   task automatic t_sequential();
      for (int i = 0; i < 5; i++)
         step(32'h0000_1234, 1'b0, 1'b0, 1'b0, exp_pc + 32'd4, "R2 sequential");
   endtask

   task automatic t_branch_fwd();
      // imm 0x0010 -> +64 bytes after PC+4
      step(32'h1000_0010, 1'b1, 1'b1, 1'b0, exp_pc + 32'd4 + 32'd64, "R3 forward branch");
   endtask

   task automatic t_branch_gated();
      step(32'h1000_0100, 1'b1, 1'b0, 1'b0, exp_pc + 32'd4, "R4 enable without zero");
      step(32'h1000_0100, 1'b0, 1'b1, 1'b0, exp_pc + 32'd4, "R4 zero without enable");
   endtask

   task automatic t_branch_back();
      // imm 0xFFF0 = -16 words -> PC + 4 - 64
      step(32'h1000_FFF0, 1'b1, 1'b1, 1'b0, exp_pc + 32'd4 - 32'd64, "R5 backward branch");
      // imm 0xFFFF: stays on the same instruction
      for (int i = 0; i < 3; i++)
         step(32'h1000_FFFF, 1'b1, 1'b1, 1'b0, exp_pc, "R5 minus-one loop");
      step(32'h1000_FFFF, 1'b0, 1'b0, 1'b0, exp_pc + 32'd4, "R5 loop exit");
   endtask

   task automatic t_jump();
      // upper six bits set to show they are ignored
      step(32'hFC00_0123, 1'b0, 1'b0, 1'b1, 32'h0000_048C, "R6 jump target");
   endtask

   task automatic t_jump_priority();
      step(32'h0800_0040, 1'b1, 1'b1, 1'b1, 32'h0000_0100, "R7 jump over branch");
   endtask

   task automatic t_region();
      step(32'h03FF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0FFF_FFFC, "R9 jump to region end");
      step(32'h0000_0005, 1'b0, 1'b0, 1'b1, 32'h1000_0014, "R9 jump into next region");
      step(32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h1000_0018, "R2 step in new region");
      step(32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h1000_0000, "R9 region held");
   endtask

   task automatic t_reset_midrun();
      rst = 1'b1; instr_word = 32'h0000_0040; br_en = 1'b1; cmp_zero = 1'b1; jmp_sel = 1'b0;
      @(posedge clk); #1;
      exp_pc = 32'd0;
      check("R1 reset during run", pc_q, 32'd0);
      rst = 1'b0;
      step(32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0004, "R2 after reset");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_sequential();
      t_branch_fwd();
      t_branch_gated();
      t_branch_back();
      t_jump();
      t_jump_priority();
      t_region();
      t_reset_midrun();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule